// File: doc/BRIEF.md
# Byte-Staged Pulse Period Register

This block holds the 16-bit period of a programmable pulse generator and feeds it to a down-counter. Software reaches the period over an 8-bit bus. It can write the upper half and the lower half as two separate accesses, or it can write the whole word in one access. Writing the upper half only places the byte in a holding slot. The lower-half write then commits the held upper byte together with the new lower byte in one clock edge. Because of this, a counter reload never sees a period that is only half written.

The block contains a small down-counter driven by an enable tick. The counter reloads from the committed period and emits a one-cycle reload pulse, so the ordering rules can be checked at the ports. Reads of either half always return the committed value. An error flag tells software that it has committed one of the two period values that the counter cannot use.

Top module: `ppg_period_buf`

## Requirements
- R1: After a synchronous reset, the committed period is 0xFFFF (`rd_hi` = `rd_lo` = 0xFF), `count` is 0xFFFF, `reload` is 0 and `period_err` is 0. The holding slot for the upper byte also resets to 0xFF, so a lower-only write right after reset gives an upper byte of 0xFF.
- R2: An upper-half write (`wr_hi`) changes only the holding slot. `rd_hi`/`rd_lo` stay the same.
- R3: A lower-half write (`wr_lo`) commits {held upper byte, `wr_byte`} as the new period. The readback shows it one cycle later.
- R4: A lower-half write with no upper-half write since the last commit reuses the upper byte of the previous commit.
- R5: A word write (`wr_word`) commits `wr_word_data` in one cycle and also loads the holding slot with its upper byte. It takes precedence over byte strobes in the same cycle.
- R6: `count` decrements by one on each cycle with `tick` high. It holds, with `reload` low, when `tick` is low.
- R7: On a tick with `count` at 1 (or 0), `count` loads the committed period and `reload` is high for exactly the following cycle. With period P, reloads recur every P ticks. From reset, the first reload comes on the 65535th tick.
- R8: A reload loads the last committed period and never a byte that is only staged.
- R9: Committing a new period while the counter runs leaves the current count untouched. The new period is used from the next reload on.
- R10: If a commit and a reload fall in the same cycle, the reload loads the period committed before that cycle.
- R11: `period_err` is high exactly while the committed period is 0x0000 or 0x0101. It updates in the same cycle as the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_hi | input | 1 | Stage `wr_byte` as upper period byte |
| wr_lo | input | 1 | Commit held upper byte with `wr_byte` as lower byte |
| wr_word | input | 1 | Commit `wr_word_data` as whole period |
| wr_byte | input | 8 | Byte write data |
| wr_word_data | input | 16 | Word write data |
| tick | input | 1 | Counter enable tick |
| rd_hi | output | 8 | Committed period, upper byte |
| rd_lo | output | 8 | Committed period, lower byte |
| count | output | 16 | Current down-counter value |
| reload | output | 1 | One-cycle pulse after each reload |
| period_err | output | 1 | Committed period is an illegal value |

## Verification
The bench goes after these corner cases:
- A reload that falls between the upper and lower writes. A design that forwards the staged byte would load a mixed period there.
- A lower-only write after a word write or after reset. This exposes a holding slot that is not refreshed or not reset to 0xFF, because the committed upper byte comes out wrong.
- A commit that lands in the very cycle of a reload, and a commit in the middle of a count. An early-forwarding design would load the new value or jump the count.
- A sweep of every lower byte under the upper bytes 0x00, 0x01 and 0x02. Any decode slip in the error flag shows up as a wrong flag value.

The bench also measures the full 65535-tick first period after reset, which catches off-by-one errors in the reload threshold.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_STAGE  = 2'd1,
    CMD_LOWER  = 2'd2,
    CMD_WORD   = 2'd3
  } wr_cmd_t;
endpackage

// File: rtl/ppg_period_stage.sv
module ppg_period_stage
  import ppg_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PER_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              wr_word,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [PER_W-1:0]  wr_word_data,
  output logic [PER_W-1:0]  period,
  output logic              period_err
);
  localparam logic [BYTE_W-1:0] BYTE_ONE = BYTE_W'(1);
  localparam logic [PER_W-1:0]  BAD_ZERO = '0;
  localparam logic [PER_W-1:0]  BAD_ONES = {BYTE_ONE, BYTE_ONE};

  logic [BYTE_W-1:0] held_hi;
  logic [PER_W-1:0]  next_period;
  wr_cmd_t           cmd;

  // word access wins over the byte strobes; lower commit beats staging
  always_comb begin
    if (wr_word)    cmd = CMD_WORD;
    else if (wr_lo) cmd = CMD_LOWER;
    else if (wr_hi) cmd = CMD_STAGE;
    else            cmd = CMD_IDLE;
  end

  always_comb begin
    case (cmd)
      CMD_WORD:  next_period = wr_word_data;
      CMD_LOWER: next_period = {held_hi, wr_byte};
      default:   next_period = period;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_hi    <= '1;
      period     <= '1;
      period_err <= 1'b0;
    end else begin
      if (cmd == CMD_STAGE) held_hi <= wr_byte;
      if (cmd == CMD_WORD)  held_hi <= wr_word_data[PER_W-1:BYTE_W];
      period     <= next_period;
      period_err <= (next_period == BAD_ZERO) || (next_period == BAD_ONES);
    end
  end

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo && !wr_word) |=> $stable(period));

  assert_lower_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_word) |=> period[BYTE_W-1:0] == $past(wr_byte));

  assert_word_commit_R5: assert property (@(posedge clk) disable iff (rst)
    wr_word |=> period == $past(wr_word_data));

  assert_err_flag_R11: assert property (@(posedge clk) disable iff (rst)
    period_err == ((period == BAD_ZERO) || (period == BAD_ONES)));
endmodule

// File: rtl/ppg_reload_counter.sv
module ppg_reload_counter #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] count,
  output logic             reload
);
  localparam logic [PER_W-1:0] LAST = PER_W'(1);

  logic at_end;
  assign at_end = (count <= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '1;
      reload <= 1'b0;
    end else if (tick) begin
      if (at_end) begin
        count  <= period;
        reload <= 1'b1;
      end else begin
        count  <= count - LAST;
        reload <= 1'b0;
      end
    end else begin
      reload <= 1'b0;
    end
  end

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(count) && !reload));

  assert_reload_value_R10: assert property (@(posedge clk) disable iff (rst)
    reload |-> count == $past(period));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (reload && count > LAST) |=> !reload);
endmodule

// File: rtl/ppg_period_buf.sv
module ppg_period_buf #(
  parameter int BYTE_W = 8,
  localparam int PER_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              wr_word,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [PER_W-1:0]  wr_word_data,
  input  logic              tick,
  output logic [BYTE_W-1:0] rd_hi,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [PER_W-1:0]  count,
  output logic              reload,
  output logic              period_err
);
  logic [PER_W-1:0] period;

  ppg_period_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk          (clk),
    .rst          (rst),
    .wr_hi        (wr_hi),
    .wr_lo        (wr_lo),
    .wr_word      (wr_word),
    .wr_byte      (wr_byte),
    .wr_word_data (wr_word_data),
    .period       (period),
    .period_err   (period_err)
  );

  ppg_reload_counter #(.PER_W(PER_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .period (period),
    .count  (count),
    .reload (reload)
  );

  assign rd_hi = period[PER_W-1:BYTE_W];
  assign rd_lo = period[BYTE_W-1:0];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (period == '1 && count == '1 && !reload && !period_err));
endmodule

// File: tb/ppg_period_buf_tb.sv
module ppg_period_buf_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_hi, wr_lo, wr_word, tick;
  logic [7:0]  wr_byte;
  logic [15:0] wr_word_data;
  logic [7:0]  rd_hi, rd_lo;
  logic [15:0] count;
  logic        reload, period_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ppg_period_buf u_dut (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_word(wr_word),
    .wr_byte(wr_byte), .wr_word_data(wr_word_data), .tick(tick),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .count(count), .reload(reload),
    .period_err(period_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input int exp);
    chk({rd_hi, rd_lo} == exp[15:0], req, {rd_hi, rd_lo}, exp);
  endtask

  task automatic put_hi(input logic [7:0] b);
    wr_hi = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_hi = 1'b0;
  endtask

  task automatic put_lo(input logic [7:0] b);
    wr_lo = 1'b1; wr_byte = b;
    @(negedge clk);
    wr_lo = 1'b0;
  endtask

  task automatic put_word(input logic [15:0] w);
    wr_word = 1'b1; wr_word_data = w;
    @(negedge clk);
    wr_word = 1'b0;
  endtask

  task automatic to_reload(input int limit, output int n);
    tick = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reload && n < limit);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; wr_hi = 0; wr_lo = 0; wr_word = 0; tick = 0;
    wr_byte = 0; wr_word_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_rd("R1 reset period", 16'hFFFF);
    chk(count == 16'hFFFF, "R1 reset count", count, 16'hFFFF);
    chk(!reload && !period_err, "R1 reset flags", {reload, period_err}, 0);

    // R7 full first period from reset
    to_reload(70000, n);
    tick = 1'b0;
    chk(n == 65535, "R7 first reload tick", n, 65535);
    chk(count == 16'hFFFF, "R7 first reload value", count, 16'hFFFF);
    @(negedge clk);
    chk(!reload, "R7 pulse one cycle", reload, 0);

    // R2 / R3 / R4 / R5 byte ordering
    put_hi(8'h12);
    chk_rd("R2 staged only", 16'hFFFF);
    put_lo(8'h34);
    chk_rd("R3 lower commit", 16'h1234);
    put_lo(8'h56);
    chk_rd("R4 lower reuses upper", 16'h1256);
    put_word(16'h0003);
    chk_rd("R5 word commit", 16'h0003);
    put_lo(8'h05);
    chk_rd("R5 word refreshes held upper", 16'h0005);
    wr_hi = 1'b1; wr_lo = 1'b1; wr_byte = 8'h77;
    put_word(16'h0A0B);
    wr_hi = 1'b0; wr_lo = 1'b0;
    chk_rd("R5 word precedence", 16'h0A0B);

    // R6 / R7 period sweep
    for (int p = 2; p <= 12; p++) begin
      put_word(16'(p));
      to_reload(70000, n);
      to_reload(100, n);
      chk(n == p, "R7 period ticks", n, p);
      chk(count == p, "R7 reload value", count, p);
    end
    tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(count == 12 && !reload, "R6 hold without tick", count, 12);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(count == 11, "R6 decrement", count, 11);

    // R8 staged byte never loaded
    put_word(16'h0004);
    to_reload(100, n);
    tick = 1'b0;
    put_hi(8'h7F);
    to_reload(100, n);
    tick = 1'b0;
    chk(count == 4 && n == 4, "R8 reload uses committed", count, 4);
    put_lo(8'h02);
    chk_rd("R8 later commit", 16'h7F02);

    // R9 commit mid count
    put_word(16'h0006);
    to_reload(40000, n);
    to_reload(100, n);
    @(negedge clk);
    tick = 1'b0;
    chk(count == 5, "R9 running count", count, 5);
    put_word(16'h0003);
    chk(count == 5, "R9 count undisturbed", count, 5);
    to_reload(100, n);
    chk(n == 5 && count == 3, "R9 new value at reload", count, 3);

    // R10 commit and reload in the same cycle
    @(negedge clk);
    @(negedge clk);
    tick = 1'b0;
    chk(count == 1, "R10 setup", count, 1);
    tick = 1'b1; wr_word = 1'b1; wr_word_data = 16'h0009;
    @(negedge clk);
    wr_word = 1'b0;
    chk(reload && count == 3, "R10 reload takes old value", count, 3);
    chk_rd("R10 commit landed", 16'h0009);
    to_reload(100, n);
    tick = 1'b0;
    chk(n == 3 && count == 9, "R10 next reload new value", count, 9);

    // R11 error flag sweep
    for (int h = 0; h <= 2; h++) begin
      for (int l = 0; l < 256; l++) begin
        put_hi(8'(h));
        put_lo(8'(l));
        chk_rd("R11 sweep readback", (h << 8) | l);
        chk(period_err == ((h == 0 && l == 0) || (h == 1 && l == 1)),
            "R11 error flag", period_err, (h == 0 && l == 0) || (h == 1 && l == 1));
      end
    end

    // R1 held upper resets to 0xFF
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    put_lo(8'h00);
    chk_rd("R1 held upper reset", 16'hFF00);
    chk(!period_err, "R11 legal after reset commit", period_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule